// File: doc/BRIEF.md
# Hysteresis FIFO Refill Request Controller

This block decides when a display pixel FIFO should ask the memory interconnect for more data. It looks at the FIFO's reported fill level together with the data it has already requested but not yet received. It compares that total against a programmed low mark and high mark. When the total falls to the low mark, the controller starts issuing burst read requests. It keeps issuing them until the total reaches the high mark. It then stays quiet until the total drains back to the low mark.

A burst is requested only when the FIFO can take the whole burst. A merge mode joins three equal FIFOs into one, which triples the capacity used for the free-space check. Software is expected to program the thresholds at three times their unmerged values in that mode.

Each request carries a byte address. The address starts from a frame base and steps forward by one burst on every accepted request. At the start of each frame it reloads from either the even-field base or the odd-field base. The choice between them is an external field indicator XORed with a polarity setting.

Top module: `fifo_refill_ctrl`

## Requirements
- R1: While reset is held and immediately after it, `req_valid` is 0, `req_addr` is 0 and no data counts as outstanding.
- R2: With valid thresholds, once occupancy (`fifo_level` plus outstanding entries) is at or below the low mark (`thr_word[11:0]`), `req_valid` rises on the cycle after the clock edge that samples it.
- R3: Requests continue while occupancy is below the high mark (`thr_word[27:16]`); `req_valid` is 0 in any cycle where occupancy is at or above the high mark.
- R4: After occupancy reaches the high mark, no request is made until occupancy has fallen back to the low mark.
- R5: `req_valid` is 1 only if capacity minus occupancy is at least `burst_len`, with capacity equal to `DEPTH` (256) entries when merge mode is off.
- R6: With `merge_en` = 1 the capacity used for the free-space check is three times `DEPTH` (768 entries).
- R7: Each accepted request (`req_valid` and `req_ready` both 1) adds `burst_len` entries to occupancy, and each `ret_beat` pulse removes one; a return pulse with nothing outstanding is ignored.
- R8: `req_addr` advances by `burst_len` shifted left by `BYTE_SHIFT` (8 bytes per entry) after each accepted request, and holds its value while a request is not accepted.
- R9: A `frame_start` pulse loads `req_addr` with `base_even` when `field_id` XOR `field_pol` is 0 and with `base_odd` when it is 1; the reload wins over a request accepted in the same cycle.
- R10: While the high mark is less than or equal to the low mark, no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_word | input | 32 | Threshold word: low mark in [11:0], high mark in [27:16] |
| merge_en | input | 1 | Treat three FIFOs as one combined FIFO |
| burst_len | input | 8 | Burst size in FIFO entries |
| fifo_level | input | 12 | Entries currently held in the FIFO |
| ret_beat | input | 1 | One entry of requested data has arrived |
| frame_start | input | 1 | Start-of-frame pulse; reloads the address |
| field_id | input | 1 | External field indicator |
| field_pol | input | 1 | Polarity applied to the field indicator |
| base_even | input | 32 | Frame base address for the even field |
| base_odd | input | 32 | Frame base address for the odd field |
| req_valid | output | 1 | Burst read request |
| req_ready | input | 1 | Interconnect accepts the request |
| req_addr | output | 32 | Byte address of the requested burst |

## Verification
Some results are combinational and appear within the same cycle as the change that causes them. These are the free-space decision, the merge capacity, the drop at the high mark and the invalid-threshold block. The bench checks them a short delay after it drives the input. Other results are registered and appear one edge later. These are the entry into refilling at the low mark, the outstanding count, the address step and the frame reload. The bench checks each of them at the falling edge that follows the rising edge that captures the stimulus. Inputs are driven only at falling edges, so no check races the register update.

// File: rtl/fifo_refill_pkg.sv
package fifo_refill_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_FILL = 1'b1} hyst_st_t;

  localparam int THR_W     = 12;
  localparam int LO_LSB    = 0;
  localparam int HI_LSB    = 16;
  localparam int MERGE_WAY = 3;

  function automatic logic [THR_W-1:0] thr_low(input logic [31:0] w);
    return w[LO_LSB +: THR_W];
  endfunction

  function automatic logic [THR_W-1:0] thr_high(input logic [31:0] w);
    return w[HI_LSB +: THR_W];
  endfunction
endpackage

// File: rtl/refill_outstanding.sv
module refill_outstanding #(
  parameter int LVL_W   = 12,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [BURST_W-1:0] burst_len,
  input  logic               ret_beat,
  output logic [LVL_W-1:0]   pending
);
  logic [LVL_W-1:0] pend_q, pend_d;
  logic             pend_en;

  always_comb begin
    pend_d = pend_q;
    if (accept)
      pend_d = pend_d + LVL_W'(burst_len);
    if (ret_beat && (pend_q != '0))
      pend_d = pend_d - LVL_W'(1);
    pend_en = accept || ret_beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= '0;
    else if (pend_en)
      pend_q <= pend_d;
  end

  assign pending = pend_q;
endmodule

// File: rtl/fill_hyst_fsm.sv
module fill_hyst_fsm
  import fifo_refill_pkg::*;
#(
  parameter int OCC_W   = 13,
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OCC_W-1:0]   occ,
  input  logic [OCC_W-1:0]   cap,
  input  logic [THR_W-1:0]   lo,
  input  logic [THR_W-1:0]   hi,
  input  logic [BURST_W-1:0] burst_len,
  output logic               filling,
  output logic               req_valid
);
  hyst_st_t         st_q, st_d;
  logic             thr_ok, at_low, at_high, room;
  logic [OCC_W-1:0] free_cnt;

  always_comb begin
    thr_ok   = hi > lo;
    at_low   = occ <= OCC_W'(lo);
    at_high  = occ >= OCC_W'(hi);
    free_cnt = (cap > occ) ? (cap - occ) : '0;
    room     = (burst_len != '0) && (free_cnt >= OCC_W'(burst_len));
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (thr_ok && at_low)    st_d = ST_FILL;
      ST_FILL: if (!thr_ok || at_high)  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= ST_IDLE;
    else
      st_q <= st_d;
  end

  assign filling   = (st_q == ST_FILL);
  assign req_valid = filling && thr_ok && !at_high && room;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int BURST_W    = 8,
  parameter int BYTE_SHIFT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               odd_sel,
  input  logic [ADDR_W-1:0]  base_even,
  input  logic [ADDR_W-1:0]  base_odd,
  input  logic               accept,
  input  logic [BURST_W-1:0] burst_len,
  output logic [ADDR_W-1:0]  step,
  output logic [ADDR_W-1:0]  sel_base,
  output logic [ADDR_W-1:0]  addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    step     = ADDR_W'(burst_len) << BYTE_SHIFT;
    sel_base = odd_sel ? base_odd : base_even;
    addr_en  = frame_start || accept;
    if (frame_start)
      addr_d = sel_base;
    else
      addr_d = addr_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr_q <= '0;
    else if (addr_en)
      addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/fifo_refill_ctrl.sv
module fifo_refill_ctrl
  import fifo_refill_pkg::*;
#(
  parameter int LVL_W      = 12,
  parameter int DEPTH      = 256,
  parameter int ADDR_W     = 32,
  parameter int BURST_W    = 8,
  parameter int BYTE_SHIFT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        thr_word,
  input  logic               merge_en,
  input  logic [BURST_W-1:0] burst_len,
  input  logic [LVL_W-1:0]   fifo_level,
  input  logic               ret_beat,
  input  logic               frame_start,
  input  logic               field_id,
  input  logic               field_pol,
  input  logic [ADDR_W-1:0]  base_even,
  input  logic [ADDR_W-1:0]  base_odd,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr
);
  localparam int OCC_W = LVL_W + 1;
  localparam logic [OCC_W-1:0] CAP_ONE   = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] CAP_MERGE = OCC_W'(DEPTH * MERGE_WAY);

  logic [LVL_W-1:0]  pending;
  logic [OCC_W-1:0]  occ, cap;
  logic [THR_W-1:0]  lo, hi;
  logic              accept, filling, odd_sel;
  logic [ADDR_W-1:0] step, sel_base;

  assign lo      = thr_low(thr_word);
  assign hi      = thr_high(thr_word);
  assign occ     = OCC_W'(fifo_level) + OCC_W'(pending);
  assign cap     = merge_en ? CAP_MERGE : CAP_ONE;
  assign accept  = req_valid && req_ready;
  assign odd_sel = field_id ^ field_pol;

  refill_outstanding #(.LVL_W(LVL_W), .BURST_W(BURST_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .accept(accept), .burst_len(burst_len),
    .ret_beat(ret_beat), .pending(pending)
  );

  fill_hyst_fsm #(.OCC_W(OCC_W), .BURST_W(BURST_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .occ(occ), .cap(cap), .lo(lo), .hi(hi),
    .burst_len(burst_len), .filling(filling), .req_valid(req_valid)
  );

  burst_addr_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .BYTE_SHIFT(BYTE_SHIFT)) u_addr (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .odd_sel(odd_sel),
    .base_even(base_even), .base_odd(base_odd), .accept(accept),
    .burst_len(burst_len), .step(step), .sel_base(sel_base), .addr(req_addr)
  );
endmodule

// File: rtl/fifo_refill_ctrl_chk.sv
module fifo_refill_ctrl_chk #(
  parameter int OCC_W   = 13,
  parameter int THR_W   = 12,
  parameter int ADDR_W  = 32,
  parameter int BURST_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               frame_start,
  input logic               filling,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [ADDR_W-1:0]  step,
  input logic [ADDR_W-1:0]  sel_base,
  input logic [OCC_W-1:0]   occ,
  input logic [OCC_W-1:0]   cap,
  input logic [THR_W-1:0]   lo,
  input logic [THR_W-1:0]   hi,
  input logic [BURST_W-1:0] burst_len
);
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !filling |-> !req_valid); // R4
  AST_REQ_BELOW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (occ < OCC_W'(hi))); // R3
  AST_REQ_THR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (hi > lo)); // R10
  AST_REQ_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((occ + OCC_W'(burst_len)) <= cap)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && !frame_start) |=> $stable(req_addr)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !frame_start) |=> (req_addr == $past(req_addr) + $past(step))); // R8
  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (req_addr == $past(sel_base))); // R9
endmodule

bind fifo_refill_ctrl fifo_refill_ctrl_chk #(
  .OCC_W(OCC_W), .THR_W(fifo_refill_pkg::THR_W), .ADDR_W(ADDR_W), .BURST_W(BURST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .frame_start(frame_start), .filling(filling), .req_addr(req_addr),
  .step(step), .sel_base(sel_base), .occ(occ), .cap(cap), .lo(lo), .hi(hi),
  .burst_len(burst_len)
);

// File: tb/fifo_refill_ctrl_test.sv
module fifo_refill_ctrl_test;
  logic        clk, rst_n;
  logic [31:0] thr_word;
  logic        merge_en;
  logic [7:0]  burst_len;
  logic [11:0] fifo_level;
  logic        ret_beat, frame_start, field_id, field_pol;
  logic [31:0] base_even, base_odd;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;

  int n_chk = 0;
  int n_bad = 0;

  fifo_refill_ctrl uut (
    .clk(clk), .rst_n(rst_n), .thr_word(thr_word), .merge_en(merge_en),
    .burst_len(burst_len), .fifo_level(fifo_level), .ret_beat(ret_beat),
    .frame_start(frame_start), .field_id(field_id), .field_pol(field_pol),
    .base_even(base_even), .base_odd(base_odd), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] thr(input int lo, input int hi);
    return {4'b0, hi[11:0], 4'b0, lo[11:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input int lo, input int hi, input int lvl);
    @(negedge clk);
    rst_n = 1'b0;
    thr_word = thr(lo, hi); merge_en = 1'b0; burst_len = 8'd16;
    fifo_level = 12'(lvl); ret_beat = 1'b0; frame_start = 1'b0;
    field_id = 1'b0; field_pol = 1'b0; req_ready = 1'b0;
    base_even = 32'h1000; base_odd = 32'h2000;
    edges(2);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(32, 200, 100);
    #1;
    check("R1 req_valid in reset", {31'b0, req_valid}, 0);
    check("R1 req_addr in reset", req_addr, 0);
    edges(1);
    check("R1 req_addr after reset", req_addr, 0);
  endtask

  task automatic t_hysteresis;
    do_reset(32, 60, 32);
    edges(1);
    check("R2 start at low mark", {31'b0, req_valid}, 1);
    req_ready = 1'b1;
    edges(1);
    check("R7 one burst pending, still below high", {31'b0, req_valid}, 1);
    edges(1);
    req_ready = 1'b0;
    check("R3 stop at high (occ 64)", {31'b0, req_valid}, 0);
    check("R8 address after two bursts", req_addr, 32'h100);
    ret_beat = 1'b1;
    edges(16);
    check("R4 quiet above low (occ 48)", {31'b0, req_valid}, 0);
    edges(16);
    ret_beat = 1'b0;
    check("R4 no request yet on arrival at low", {31'b0, req_valid}, 0);
    edges(1);
    check("R2 restart after drain to low", {31'b0, req_valid}, 1);
    ret_beat = 1'b1;
    edges(2);
    ret_beat = 1'b0;
    #1;
    check("R7 stray return beats ignored", {31'b0, req_valid}, 1);
  endtask

  task automatic t_address;
    do_reset(32, 200, 100);
    frame_start = 1'b1;
    edges(1);
    frame_start = 1'b0;
    check("R9 even base load", req_addr, 32'h1000);
    check("R2 no request above low", {31'b0, req_valid}, 0);
    fifo_level = 12'd32;
    edges(1);
    check("R2 request after level drops", {31'b0, req_valid}, 1);
    req_ready = 1'b1;
    edges(1);
    req_ready = 1'b0;
    check("R8 step by 16 entries", req_addr, 32'h1080);
    edges(1);
    check("R8 hold while not accepted", req_addr, 32'h1080);
    field_id = 1'b1; frame_start = 1'b1; req_ready = 1'b1;
    edges(1);
    req_ready = 1'b0;
    check("R9 odd base wins over accept", req_addr, 32'h2000);
    field_pol = 1'b1;
    edges(1);
    check("R9 id1 pol1 selects even", req_addr, 32'h1000);
    field_id = 1'b0;
    edges(1);
    frame_start = 1'b0;
    check("R9 id0 pol1 selects odd", req_addr, 32'h2000);
  endtask

  task automatic t_space;
    do_reset(200, 800, 200);
    edges(1);
    check("R5 room for burst", {31'b0, req_valid}, 1);
    fifo_level = 12'd245; #1;
    check("R5 free 11 < 16", {31'b0, req_valid}, 0);
    fifo_level = 12'd240; #1;
    check("R5 free exactly 16", {31'b0, req_valid}, 1);
    fifo_level = 12'd241; #1;
    check("R5 free 15", {31'b0, req_valid}, 0);
    merge_en = 1'b1; fifo_level = 12'd245; #1;
    check("R6 merged capacity", {31'b0, req_valid}, 1);
    fifo_level = 12'd752; #1;
    check("R6 merged free exactly 16", {31'b0, req_valid}, 1);
    fifo_level = 12'd753; #1;
    check("R6 merged free 15", {31'b0, req_valid}, 0);
  endtask

  task automatic t_invalid;
    do_reset(50, 50, 0);
    edges(3);
    check("R10 equal marks block requests", {31'b0, req_valid}, 0);
    thr_word = thr(50, 51);
    edges(1);
    check("R10 valid marks allow requests", {31'b0, req_valid}, 1);
    thr_word = thr(50, 40); #1;
    check("R10 high below low blocks at once", {31'b0, req_valid}, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_hysteresis();
    t_address();
    t_space();
    t_invalid();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule